// File: doc/BRIEF.md
# Operation Status Poller

This block forms the byte that a read returns while an internally timed write of the storage array is running. Two kinds of operation are covered: programming one byte, and erasing a sector or the whole array. The timer that runs the operation supplies a busy flag and a flag that marks an erase. The write path supplies the top bit of the byte most recently loaded for programming. The array supplies its read data. A one-cycle read strobe marks each read that the host performs.

While no operation runs, the block passes the array data through unchanged. While an operation runs, two bits carry status. The polled bit (bit 7) returns the complement of the target value. For a byte program this is the inverse of the loaded byte's top bit. For an erase it is 0, because erased cells read as 1. The toggle bit (bit 6) flips once for every read strobe, so any two successive reads differ. The remaining bits pass through the array data. The host may start polling at any point in the operation and needs no setup step. Once the timer drops busy, reads return true data and the toggle bit stops moving.

The toggle state is held at 0 whenever no operation runs, so the first read of every operation shows bit 6 low. The kind of operation is sampled in the cycle that busy rises and is held until busy falls.

Top module: `opStatusPoller`

## Requirements
- R1: While opBusy is low, readData equals arrayData on all eight bits.
- R2: During a byte program (opIsErase low in the cycle opBusy rose), readData bit 7 is the inverse of loadedPollBit.
- R3: During an erase (opIsErase high in the cycle opBusy rose), readData bit 7 reads 0.
- R4: While opBusy stays high, each cycle with readStrobe high causes readData bit 6 in the next cycle to be the opposite of its value in the strobe cycle, so two back-to-back reads differ.
- R5: While opBusy stays high, a cycle with readStrobe low leaves readData bit 6 unchanged in the next cycle.
- R6: The first read of every operation returns readData bit 6 as 0, whatever number of reads the previous operation saw.
- R7: While opBusy is high, readData bits 5 down to 0 equal the corresponding bits of arrayData.
- R8: A change of opIsErase after the cycle in which opBusy rose has no effect on readData bit 7 until opBusy falls.
- R9: While rstN is low, the toggle state is held at 0, so readData bit 6 reads 0 while busy and reset is asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| opBusy | input | 1 | High while a program or erase operation is running |
| opIsErase | input | 1 | Marks the operation as an erase; sampled when opBusy rises |
| loadedPollBit | input | 1 | Bit 7 of the byte most recently loaded for programming |
| readStrobe | input | 1 | One-cycle pulse for each host read |
| arrayData | input | 8 | Data read from the storage array |
| readData | output | 8 | Byte returned to the host on a read |

## Verification
The bench checks the toggle bit against reads that come back to back, against gaps with no strobe, and against a long run of reads. A design that advanced the toggle on idle clocks would show bit 6 moving between reads, and a design that skipped a flip would return two equal reads. An operation that ends after an odd number of reads is followed at once by a new one, so a toggle that was not cleared between operations would start the next one at 1. The erase flag is dropped partway through an erase, so a design that decoded the flag live would switch bit 7 to the program form. A reset is asserted while busy to show that the toggle is cleared, and idle vectors check that status never leaks into plain reads.

// File: rtl/pollerPkg.sv
package pollerPkg;

  // Strobes from the control half to the datapath half.
  typedef struct packed {
    logic clearToggle;    // hold toggle state at zero
    logic advanceToggle;  // flip toggle state at this edge
    logic showStatus;     // replace status bits on the read bus
    logic eraseMode;      // running operation is an erase
  } pollStrobes_t;

endpackage

// File: rtl/pollerCtrl.sv
module pollerCtrl
  import pollerPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         opBusy,
  input  logic         opIsErase,
  input  logic         readStrobe,
  output pollStrobes_t strobes
);

  logic busyQ;
  logic eraseQ;
  logic startCycle;

  assign startCycle = opBusy & ~busyQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ  <= 1'b0;
      eraseQ <= 1'b0;
    end else begin
      busyQ <= opBusy;
      if (startCycle) begin
        eraseQ <= opIsErase;
      end
    end
  end

  always_comb begin
    strobes.clearToggle   = ~opBusy;
    strobes.advanceToggle = opBusy & readStrobe;
    strobes.showStatus    = opBusy;
    strobes.eraseMode     = startCycle ? opIsErase : eraseQ;
  end

endmodule

// File: rtl/pollerDatapath.sv
module pollerDatapath
  import pollerPkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int POLL_BIT   = 7,
  parameter int TOGGLE_BIT = 6,
  parameter bit ERASED_VAL = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  pollStrobes_t      strobes,
  input  logic              loadedPollBit,
  input  logic [DATA_W-1:0] arrayData,
  output logic [DATA_W-1:0] readData
);

  localparam logic ERASE_BUSY_VAL = ~ERASED_VAL;

  logic toggleQ;
  logic pollVal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      toggleQ <= 1'b0;
    end else if (strobes.clearToggle) begin
      toggleQ <= 1'b0;
    end else if (strobes.advanceToggle) begin
      toggleQ <= ~toggleQ;
    end
  end

  assign pollVal = strobes.eraseMode ? ERASE_BUSY_VAL : ~loadedPollBit;

  for (genvar i = 0; i < DATA_W; i++) begin : gBit
    if (i == POLL_BIT) begin : gPoll
      assign readData[i] = strobes.showStatus ? pollVal : arrayData[i];
    end else if (i == TOGGLE_BIT) begin : gToggle
      assign readData[i] = strobes.showStatus ? toggleQ : arrayData[i];
    end else begin : gPass
      assign readData[i] = arrayData[i];
    end
  end

endmodule

// File: rtl/opStatusPoller.sv
module opStatusPoller
  import pollerPkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int POLL_BIT   = 7,
  parameter int TOGGLE_BIT = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opBusy,
  input  logic              opIsErase,
  input  logic              loadedPollBit,
  input  logic              readStrobe,
  input  logic [DATA_W-1:0] arrayData,
  output logic [DATA_W-1:0] readData
);

  pollStrobes_t strobes;

  pollerCtrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .opBusy     (opBusy),
    .opIsErase  (opIsErase),
    .readStrobe (readStrobe),
    .strobes    (strobes)
  );

  pollerDatapath #(
    .DATA_W     (DATA_W),
    .POLL_BIT   (POLL_BIT),
    .TOGGLE_BIT (TOGGLE_BIT),
    .ERASED_VAL (1'b1)
  ) uData (
    .clk           (clk),
    .rstN          (rstN),
    .strobes       (strobes),
    .loadedPollBit (loadedPollBit),
    .arrayData     (arrayData),
    .readData      (readData)
  );

endmodule

// File: rtl/opStatusPollerChk.sv
module opStatusPollerChk #(
  parameter int DATA_W     = 8,
  parameter int POLL_BIT   = 7,
  parameter int TOGGLE_BIT = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              opBusy,
  input logic              opIsErase,
  input logic              loadedPollBit,
  input logic              readStrobe,
  input logic [DATA_W-1:0] arrayData,
  input logic [DATA_W-1:0] readData
);

  logic armed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  a_r1_idle_passthru: assert property (@(posedge clk) disable iff (!rstN)
    !opBusy |-> readData == arrayData);

  a_r2_program_poll: assert property (@(posedge clk) disable iff (!rstN)
    (armed && opBusy && !$past(opBusy) && !opIsErase)
      |-> readData[POLL_BIT] != loadedPollBit);

  a_r3_erase_poll: assert property (@(posedge clk) disable iff (!rstN)
    (armed && opBusy && !$past(opBusy) && opIsErase) |-> !readData[POLL_BIT]);

  a_r4_toggle_on_read: assert property (@(posedge clk) disable iff (!rstN)
    (armed && opBusy && $past(opBusy) && $past(readStrobe))
      |-> readData[TOGGLE_BIT] != $past(readData[TOGGLE_BIT]));

  a_r5_hold_without_read: assert property (@(posedge clk) disable iff (!rstN)
    (armed && opBusy && $past(opBusy) && !$past(readStrobe))
      |-> readData[TOGGLE_BIT] == $past(readData[TOGGLE_BIT]));

  a_r6_first_read_low: assert property (@(posedge clk) disable iff (!rstN)
    (armed && opBusy && !$past(opBusy)) |-> !readData[TOGGLE_BIT]);

  a_r8_mode_held: assert property (@(posedge clk) disable iff (!rstN)
    (armed && opBusy && $past(opBusy) && $past(loadedPollBit) == loadedPollBit)
      |-> $stable(readData[POLL_BIT]));

endmodule

bind opStatusPoller opStatusPollerChk #(
  .DATA_W     (DATA_W),
  .POLL_BIT   (POLL_BIT),
  .TOGGLE_BIT (TOGGLE_BIT)
) uChk (
  .clk           (clk),
  .rstN          (rstN),
  .opBusy        (opBusy),
  .opIsErase     (opIsErase),
  .loadedPollBit (loadedPollBit),
  .readStrobe    (readStrobe),
  .arrayData     (arrayData),
  .readData      (readData)
);

// File: tb/tb_opStatusPoller.sv
module tb_opStatusPoller;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;

  logic       clk = 1'b0;
  logic       rstN;
  logic       opBusy;
  logic       opIsErase;
  logic       loadedPollBit;
  logic       readStrobe;
  logic [7:0] arrayData;
  logic [7:0] readData;

  int  checks = 0;
  int  failures = 0;
  bit  finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  opStatusPoller dut (
    .clk           (clk),
    .rstN          (rstN),
    .opBusy        (opBusy),
    .opIsErase     (opIsErase),
    .loadedPollBit (loadedPollBit),
    .readStrobe    (readStrobe),
    .arrayData     (arrayData),
    .readData      (readData)
  );

  // {busy, erase, strobe, loadedBit, array[7:0], expected[7:0], reqTag[3:0]}
  localparam logic [23:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 1'b1, 1'b0, 8'h5A, 8'h5A, 4'd1}, // R1 idle, strobe ignored
    {1'b1, 1'b0, 1'b1, 1'b0, 8'h3C, 8'hBC, 4'd2}, // R2 program start
    {1'b1, 1'b0, 1'b1, 1'b0, 8'h3C, 8'hFC, 4'd4}, // R4 second read differs
    {1'b1, 1'b0, 1'b0, 1'b0, 8'h3C, 8'hBC, 4'd4}, // R4 flipped back
    {1'b1, 1'b0, 1'b0, 1'b0, 8'h3C, 8'hBC, 4'd5}, // R5 no strobe, held
    {1'b1, 1'b0, 1'b1, 1'b1, 8'hFF, 8'h3F, 4'd2}, // R2 loaded bit 1
    {1'b0, 1'b0, 1'b0, 1'b0, 8'hC3, 8'hC3, 4'd1}, // R1 done, true data
    {1'b1, 1'b1, 1'b1, 1'b0, 8'hFF, 8'h3F, 4'd6}, // R6 / R3 erase start
    {1'b1, 1'b0, 1'b1, 1'b0, 8'hFF, 8'h7F, 4'd8}, // R8 flag dropped mid-erase
    {1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00, 4'd3}, // R3 / R7 low bits follow array
    {1'b0, 1'b0, 1'b1, 1'b0, 8'hA5, 8'hA5, 4'd1}, // R1 idle again
    {1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h80, 4'd6}  // R6 next op starts low
  };

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s readData actual=%02h expected=%02h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rstN = 1'b0;
    opBusy = 1'b0;
    opIsErase = 1'b0;
    loadedPollBit = 1'b0;
    readStrobe = 1'b0;
    arrayData = 8'h96;
    repeat (3) @(negedge clk);
    #1 check("R1 reset idle", readData, 8'h96);
    @(negedge clk);
    rstN = 1'b1;

    for (int v = 0; v < NVEC; v++) begin
      @(negedge clk);
      {opBusy, opIsErase, readStrobe, loadedPollBit, arrayData} = VEC[v][23:12];
      #1 check($sformatf("R%0d vec%0d", VEC[v][3:0], v), readData, VEC[v][11:4]);
    end

    // Leave the program op from the last vector, then start a fresh one.
    @(negedge clk);
    opBusy = 1'b0;
    readStrobe = 1'b0;
    arrayData = 8'h15;
    @(negedge clk);
    opBusy = 1'b1;
    opIsErase = 1'b0;
    loadedPollBit = 1'b1;
    readStrobe = 1'b1;
    // R4: long run of back-to-back reads alternates from 0; R7 low bits pass
    for (int i = 0; i < 16; i++) begin
      #1 check("R4 run", readData, {1'b0, i[0], 6'h15});
      @(negedge clk);
    end

    // R9: reset while busy and reading clears the toggle state
    readStrobe = 1'b1;
    @(negedge clk);  // toggle now 1 after 17 reads
    #1 check("R4 before reset", readData, {1'b0, 1'b1, 6'h15});
    rstN = 1'b0;
    #1 check("R9 reset while busy", readData, {1'b0, 1'b0, 6'h15});
    @(negedge clk);
    #1 check("R9 held in reset", readData, {1'b0, 1'b0, 6'h15});
    readStrobe = 1'b0;
    rstN = 1'b1;

    // R5: many idle clocks while busy leave bit 6 unchanged
    repeat (5) @(negedge clk);
    #1 check("R5 idle clocks", readData, {1'b0, 1'b0, 6'h15});

    // R3 + R8: erase with flag pulsed only at start; loaded bit changes ignored
    @(negedge clk);
    opBusy = 1'b0;
    @(negedge clk);
    opBusy = 1'b1;
    opIsErase = 1'b1;
    loadedPollBit = 1'b0;
    @(negedge clk);
    opIsErase = 1'b0;
    #1 check("R8 erase mode held", readData, {1'b0, 1'b0, 6'h15});
    opIsErase = 1'b1;
    #1 check("R3 erase bit7 low", readData, {1'b0, 1'b0, 6'h15});

    @(negedge clk);
    opBusy = 1'b0;
    arrayData = 8'hE7;
    #1 check("R1 true data after erase", readData, 8'hE7);

    finish_run();
  end

endmodule